// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Status Flags

This block recovers asynchronous serial characters from a single input line. It runs from one clock whose rate is sixteen times the bit rate. An idle line is high. A falling edge opens a candidate frame. The receiver then confirms the start bit at its centre and takes every later bit at its centre. Bits arrive least significant first. The character length (five to eight bits) and the parity mode (odd, even or none) come from static format inputs. These are the same controls that set up the companion transmitter.

When the first stop bit is reached, the assembled character moves into an eight-bit result register and the parity and overrun flags are updated. One clock later the data-ready flag rises and the framing flag is updated. The receiver looks for the next start edge from the middle of the first stop bit onward, so characters may follow each other closely. The host clears data-ready by driving an active-low clear input. A master reset clears every flag and leaves the last character in place.

Top module: `async_rx`

## Requirements
- R1: While `rst` is high, and afterwards until a character is loaded, `dataReady`, `parErr`, `frmErr` and `ovrErr` are 0. A reset does not change `rxData`.
- R2: A frame begins only on a high-to-low change of `serIn`. If the line has returned high at the start-bit centre, the edge is dropped, nothing is loaded and no flag changes.
- R3: Each bit is taken at its centre, least significant bit first. `rxData` takes the new character on the 10th rising edge of `clk` counted from the first rising edge at which `serIn` carries the first stop bit.
- R4: `lenSel` gives the character length as 5 + `lenSel` (00=5, 01=6, 10=7, 11=8 bits). The character is right-justified in `rxData` and the unused upper bits read 0.
- R5: With `parityOff`=0, one parity bit follows the data. `parityEven`=1 expects an even count of ones over data plus parity, and `parityEven`=0 expects an odd count. `parErr` is 1 when the count is wrong and is updated on the same edge as `rxData`. With `parityOff`=1 no parity bit is expected and `parErr` is loaded with 0.
- R6: On the edge that loads `rxData`, `ovrErr` takes the value 1 if `dataReady` was still 1, and the value 0 otherwise.
- R7: One clock after `rxData` loads (the 11th edge of R3), `dataReady` goes to 1 and `frmErr` becomes 1 if the first stop bit was sampled low, or 0 if it was sampled high.
- R8: While `drClearN` is 0, `dataReady` is cleared on each rising edge, and clearing takes priority over setting.
- R9: The receiver accepts a new start edge from the centre of the first stop bit onward. A next start bit that begins 11 clocks into a stop bit is received correctly.
- R10: `parErr`, `ovrErr` and `frmErr` keep their values between character loads. `drClearN` does not affect them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at sixteen times the bit rate |
| rst | input | 1 | Master reset, active high |
| serIn | input | 1 | Serial line, high when idle |
| lenSel | input | 2 | Character length select, length = 5 + value |
| parityOff | input | 1 | 1: no parity bit, parity flag held low |
| parityEven | input | 1 | 1: even parity expected, 0: odd |
| drClearN | input | 1 | Active-low clear of the data-ready flag |
| rxData | output | 8 | Last received character, right-justified |
| dataReady | output | 1 | A character has been loaded and not yet cleared |
| parErr | output | 1 | Parity mismatch on the last character |
| frmErr | output | 1 | First stop bit of the last character was low |
| ovrErr | output | 1 | Last character overwrote an unread one |

## Verification
The timing of each result is fixed by the delay through two synchronizer flops and one edge-detect register. `rxData`, `parErr` and `ovrErr` are due on the 10th rising edge after the stop bit appears on `serIn`. `dataReady` and `frmErr` are due one edge later, and a clear through `drClearN` shows on the next edge. The bench drives `serIn` on falling edges and counts rising edges from the stop-bit change. It reads the first group right after the 10th edge and checks that `dataReady` is still low there, then reads `dataReady` and `frmErr` right after the 11th.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int MIN_W  = DATA_W - 3;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rxState_t;

  // strobes from the sequencer to the datapath, valid for one clock
  typedef struct packed {
    logic             startFrame;
    logic             sampleData;
    logic             sampleParity;
    logic             transfer;
    logic [IDX_W-1:0] bitIdx;
  } rxStb_t;

endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       serIn,
  input  logic [1:0] lenSel,
  input  logic       parityOff,
  output logic       lineS,
  output rxStb_t     stb
);

  localparam int CNT_W = $clog2(OVS);
  // the synchronizer and edge register add two clocks; the centre of the
  // start bit lies 7.5 sub-periods after the line fell
  localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OVS / 2 - 2);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OVS - 1);

  logic             syncA;
  logic             prevLine;
  rxState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;
  logic             atMid;
  logic             atLast;

  assign lastIdx = IDX_W'(MIN_W - 1) + IDX_W'(lenSel);
  assign atMid   = (cnt == MID_C);
  assign atLast  = (cnt == LAST_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA    <= 1'b1;
      lineS    <= 1'b1;
      prevLine <= 1'b1;
    end else begin
      syncA    <= serIn;
      lineS    <= syncA;
      prevLine <= lineS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (!lineS && prevLine) state <= RX_START;
        end
        RX_START: begin
          if (atMid) begin
            cnt   <= '0;
            idx   <= '0;
            state <= lineS ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          cnt <= cnt + 1'b1;
          if (atLast) begin
            if (idx == lastIdx) state <= parityOff ? RX_STOP : RX_PAR;
            else                idx   <= idx + 1'b1;
          end
        end
        RX_PAR: begin
          cnt <= cnt + 1'b1;
          if (atLast) state <= RX_STOP;
        end
        RX_STOP: begin
          cnt <= cnt + 1'b1;
          if (atLast) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.startFrame   = (state == RX_START) && atMid && !lineS;
    stb.sampleData   = (state == RX_DATA)  && atLast;
    stb.sampleParity = (state == RX_PAR)   && atLast;
    stb.transfer     = (state == RX_STOP)  && atLast;
    stb.bitIdx       = idx;
  end

endmodule

// File: rtl/srx_dpath.sv
module srx_dpath
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lineS,
  input  rxStb_t            stb,
  input  logic              parityOff,
  input  logic              parityEven,
  input  logic              drClearN,
  output logic [DATA_W-1:0] rxData,
  output logic              dataReady,
  output logic              parErr,
  output logic              frmErr,
  output logic              ovrErr
);

  logic [DATA_W-1:0] shReg;
  logic              parBit;
  logic              stopBit;
  logic              xferD;

  // assembly register and received character; no reset on purpose
  always_ff @(posedge clk) begin
    if (stb.startFrame)        shReg <= '0;
    else if (stb.sampleData)   shReg[stb.bitIdx] <= lineS;
    if (stb.sampleParity)      parBit <= lineS;
    if (stb.transfer) begin
      rxData  <= shReg;
      stopBit <= lineS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xferD     <= 1'b0;
      dataReady <= 1'b0;
      parErr    <= 1'b0;
      frmErr    <= 1'b0;
      ovrErr    <= 1'b0;
    end else begin
      xferD <= stb.transfer;
      if (stb.transfer) begin
        ovrErr <= dataReady;
        parErr <= parityOff ? 1'b0 : ((^shReg) ^ parBit ^ ~parityEven);
      end
      if (xferD) frmErr <= ~stopBit;
      if (!drClearN)  dataReady <= 1'b0;
      else if (xferD) dataReady <= 1'b1;
    end
  end

endmodule

// File: rtl/async_rx.sv
module async_rx
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       serIn,
  input  logic [1:0] lenSel,
  input  logic       parityOff,
  input  logic       parityEven,
  input  logic       drClearN,
  output logic [7:0] rxData,
  output logic       dataReady,
  output logic       parErr,
  output logic       frmErr,
  output logic       ovrErr
);

  logic   lineS;
  rxStb_t ctrlStb;

  srx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .serIn     (serIn),
    .lenSel    (lenSel),
    .parityOff (parityOff),
    .lineS     (lineS),
    .stb       (ctrlStb)
  );

  srx_dpath u_dpath (
    .clk        (clk),
    .rst        (rst),
    .lineS      (lineS),
    .stb        (ctrlStb),
    .parityOff  (parityOff),
    .parityEven (parityEven),
    .drClearN   (drClearN),
    .rxData     (rxData),
    .dataReady  (dataReady),
    .parErr     (parErr),
    .frmErr     (frmErr),
    .ovrErr     (ovrErr)
  );

endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk (
  input logic clk,
  input logic rst,
  input logic drClearN,
  input logic parityOff,
  input logic xferStb,
  input logic dataReady,
  input logic parErr,
  input logic frmErr,
  input logic ovrErr
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!dataReady && !parErr && !frmErr && !ovrErr));

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    !drClearN |=> !dataReady);

  a_r7_ready_follows_load: assert property (@(posedge clk) disable iff (rst)
    $rose(dataReady) |-> $past(xferStb, 2));

  a_r6_overrun_copy: assert property (@(posedge clk) disable iff (rst)
    xferStb |=> (ovrErr == $past(dataReady)));

  a_r5_inhibit_low: assert property (@(posedge clk) disable iff (rst)
    (xferStb && parityOff) |=> !parErr);

  a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !xferStb |=> ($stable(parErr) && $stable(ovrErr)));

endmodule

bind async_rx async_rx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .drClearN  (drClearN),
  .parityOff (parityOff),
  .xferStb   (ctrlStb.transfer),
  .dataReady (dataReady),
  .parErr    (parErr),
  .frmErr    (frmErr),
  .ovrErr    (ovrErr)
);

// File: tb/async_rx_tb.sv
`timescale 1ns/1ps
module async_rx_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serIn = 1'b1;
  logic [1:0] lenSel = 2'b11;
  logic       parityOff = 1'b1;
  logic       parityEven = 1'b0;
  logic       drClearN = 1'b1;
  logic [7:0] rxData;
  logic       dataReady, parErr, frmErr, ovrErr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  async_rx u_dut (
    .clk(clk), .rst(rst), .serIn(serIn), .lenSel(lenSel),
    .parityOff(parityOff), .parityEven(parityEven), .drClearN(drClearN),
    .rxData(rxData), .dataReady(dataReady), .parErr(parErr),
    .frmErr(frmErr), .ovrErr(ovrErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finishRun();
    end
  end

  task automatic idle(input int n);
    serIn = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic clearReady(input string req);
    @(negedge clk) drClearN = 1'b0;
    @(negedge clk) drClearN = 1'b1;
    chk(req, dataReady, 0);
  endtask

  // parMode: 0 none, 1 correct, 2 inverted. Returns just after the 10th edge
  // following the stop-bit change.
  task automatic sendChar(input logic [7:0] d, input int nb, input int parMode,
                          input logic stopVal);
    logic p;
    p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    if (!parityEven) p = ~p;
    if (parMode == 2) p = ~p;
    serIn = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      serIn = d[i];
      repeat (16) @(negedge clk);
    end
    if (parMode != 0) begin
      serIn = p;
      repeat (16) @(negedge clk);
    end
    serIn = stopVal;
    repeat (10) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nextEdge();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 dataReady", dataReady, 0);
    chk("R1 parErr", parErr, 0);
    chk("R1 frmErr", frmErr, 0);
    chk("R1 ovrErr", ovrErr, 0);
  endtask

  task automatic t_eightBit();
    lenSel = 2'b11; parityOff = 1'b1;
    sendChar(8'hA5, 8, 0, 1'b1);
    chk("R3 data at 10th edge", rxData, 8'hA5);
    chk("R7 ready not before 11th edge", dataReady, 0);
    chk("R6 no overrun", ovrErr, 0);
    nextEdge();
    chk("R7 ready at 11th edge", dataReady, 1);
    chk("R7 frame ok", frmErr, 0);
    idle(10);
  endtask

  task automatic t_fiveEven();
    clearReady("R8 clear");
    lenSel = 2'b00; parityOff = 1'b0; parityEven = 1'b1;
    sendChar(8'hF5, 5, 1, 1'b1);
    chk("R4 five bits right-justified", rxData, 8'h15);
    chk("R5 even parity good", parErr, 0);
    nextEdge();
    chk("R7 ready", dataReady, 1);
    idle(10);
  endtask

  task automatic t_sevenOddBad();
    clearReady("R8 clear");
    lenSel = 2'b10; parityOff = 1'b0; parityEven = 1'b0;
    sendChar(8'h5B, 7, 2, 1'b1);
    chk("R4 seven bits", rxData, 8'h5B);
    chk("R5 odd parity mismatch", parErr, 1);
    nextEdge();
    idle(40);
    chk("R10 parErr held", parErr, 1);
    clearReady("R8 clear");
    chk("R10 parErr unaffected by clear", parErr, 1);
  endtask

  task automatic t_sixInhibit();
    lenSel = 2'b01; parityOff = 1'b1;
    sendChar(8'hEA, 6, 0, 1'b1);
    chk("R4 six bits", rxData, 8'h2A);
    chk("R5 inhibited parity low", parErr, 0);
    nextEdge();
    idle(10);
  endtask

  task automatic t_framing();
    clearReady("R8 clear");
    lenSel = 2'b11; parityOff = 1'b1;
    sendChar(8'h3C, 8, 0, 1'b0);
    chk("R3 data with bad stop", rxData, 8'h3C);
    nextEdge();
    chk("R7 framing error", frmErr, 1);
    chk("R7 ready on bad stop", dataReady, 1);
    idle(30);
    chk("R10 frmErr held", frmErr, 1);
  endtask

  task automatic t_overrun();
    sendChar(8'h81, 8, 0, 1'b1);
    chk("R6 overrun set", ovrErr, 1);
    nextEdge();
    chk("R7 frame cleared", frmErr, 0);
    idle(10);
    clearReady("R8 clear");
    sendChar(8'h7E, 8, 0, 1'b1);
    chk("R6 overrun cleared", ovrErr, 0);
    chk("R3 data", rxData, 8'h7E);
    nextEdge();
    idle(10);
  endtask

  task automatic t_glitch();
    clearReady("R8 clear");
    serIn = 1'b0;
    repeat (3) @(negedge clk);
    idle(300);
    chk("R2 glitch no ready", dataReady, 0);
    chk("R2 glitch no load", rxData, 8'h7E);
    sendChar(8'h99, 8, 0, 1'b1);
    chk("R2 frame after glitch", rxData, 8'h99);
    nextEdge();
  endtask

  task automatic t_backToBack();
    sendChar(8'h42, 8, 0, 1'b1);
    chk("R9 second char", rxData, 8'h42);
    nextEdge();
    idle(10);
  endtask

  task automatic t_midReset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 flags cleared", {dataReady, parErr, frmErr, ovrErr}, 0);
    chk("R1 data kept", rxData, 8'h42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    idle(5);
    t_reset();
    t_eightBit();
    t_fiveEven();
    t_sevenOddBad();
    t_sixInhibit();
    t_framing();
    t_overrun();
    t_glitch();
    t_backToBack();
    t_midReset();
    finishRun();
  end

endmodule